// File: doc/BRIEF.md
# Four-Bank Register File with Steering Word

This block holds the general register state of a CPU core. It has four banks. Every bank keeps the byte registers A, F, B, C, D, E, H and L and the index registers IX and IY, and each of these has an alternate copy. The pairs B/C, D/E and H/L act as 16-bit word registers. Each pair also owns a 16-bit upper extension, which makes it a 32-bit register. The extension is reachable only in long-word mode or through a half-swap.

A 32-bit steering word decides which copy every access reaches. It picks the bank for the main registers, for IX and for IY independently. It also picks the primary or alternate copy of IX, of IY, of AF and of the B..L set, and it holds the word or long-word mode bit. Software reads and writes the steering word through its own plain port. It can write the whole word, one of the upper three bytes, or one byte copied into all three upper bytes at once. Pushing and popping the steering word is a whole-word read followed later by a whole-word write.

Register accesses travel on a valid/ready request channel, and every accepted request produces one item on a valid/ready response channel. That item carries the register value as it was before the access. A request is accepted only when `req_ready` is high. `req_ready` is low while a response is waiting and `rsp_ready` is low. A waiting response keeps `rsp_data` unchanged until it is taken.

Top module: `bankreg_core`

## Requirements
- R1: After reset, `sel_rdata` reads 0, and every register in every bank and copy reads 0.
- R2: The steering word uses these bits. Bits 9:8 are the main bank, bit 14 is long-word mode, bit 16 is the IX alternate, bits 18:17 are the IX bank, bit 24 is the IY alternate and bits 26:25 are the IY bank. Bit 1 is the B..L alternate and bit 0 is the AF alternate. Every other bit reads 0. With `sel_kind` 0 the whole word is written, masked to these bits, and `sel_rdata` shows it after the next edge.
- R3: With `sel_kind` 1, `sel_wdata[7:0]` is written into byte `sel_byte` (1 to 3) and the other bytes are unchanged. A `sel_byte` of 0 changes nothing.
- R4: With `sel_kind` 2, `sel_wdata[7:0]` is written into bytes 1, 2 and 3 (masked as in R2), and byte 0 is unchanged.
- R5: A steering write takes effect on the next clock edge. A register access accepted in the same cycle uses the old steering word.
- R6: Byte accesses (`req_op` 0) use `req_id` 0..7 for A, F, B, C, D, E, H and L in the main bank. The banks hold separate values.
- R7: Word ids 4 (IX) and 5 (IY) use their own bank field and alternate bit, independent of the main bank and of each other.
- R8: The B..L alternate bit switches B, C, D, E, H and L but not A or F. The AF alternate bit switches A and F but not B..L.
- R9: Word accesses (`req_op` 1) use id 0 AF, 1 BC, 2 DE, 3 HL, 4 IX, 5 IY; ids 6 and 7 read 0. The first-named register is the high byte. In word mode a read returns 0 in bits 31:16, and a write leaves the extension unchanged.
- R10: In long-word mode a word access to BC, DE or HL reads and writes the extension in bits 31:16. AF, IX and IY still read 0 there.
- R11: A swap (`req_op` 2) on ids 1..3 exchanges the extension with the low 16 bits, whatever the mode and `req_wr`. On other ids it changes nothing and returns 0.
- R12: Each accepted request gives exactly one response, in order. A response that is not taken holds `rsp_valid` and `rsp_data`, and `req_ready` stays low meanwhile.
- R13: The response carries the value before the access, sized as a read of the same op (for a swap, the full 32 bits). A write therefore returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 0 byte, 1 word (mode-sized), 2 half-swap, 3 no operation |
| req_wr | input | 1 | Write when high, read when low |
| req_id | input | 3 | Register id, coded per op |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response item present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Register value before the access |
| sel_wr | input | 1 | Steering word write strobe |
| sel_kind | input | 2 | 0 whole, 1 single upper byte, 2 copy to all upper bytes, 3 ignored |
| sel_byte | input | 2 | Byte index for a single-byte write |
| sel_wdata | input | 32 | Steering write data |
| sel_rdata | output | 32 | Current steering word |

## Verification
A wrong steering bit or a misrouted bank index shows up as a wrong `rsp_data` one cycle after the request is accepted. The bench writes distinct values into different banks and copies, then reads them back after each steering change, so a mix-up between groups surfaces in the first read after the change. Extension and swap errors show only in long-word reads, so each word-mode write is followed by a long-word read of the same pair. Handshake faults show as a lost, repeated or changed response while back-pressure is applied.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 2 * BYTE_W;
  localparam int LONG_W    = 2 * WORD_W;
  localparam int NUM_BYTES = 8;
  localparam int NUM_PAIRS = 3;
  localparam int ID_W      = $clog2(NUM_BYTES);

  localparam int POS_AF_ALT  = 0;
  localparam int POS_SET_ALT = 1;
  localparam int POS_MAIN_BK = 8;
  localparam int POS_LONG    = 14;
  localparam int POS_IX_ALT  = 16;
  localparam int POS_IX_BK   = 17;
  localparam int POS_IY_ALT  = 24;
  localparam int POS_IY_BK   = 25;

  localparam logic [LONG_W-1:0] STEER_MASK = 32'h0707_4303;

  typedef enum logic [1:0] {OP_BYTE, OP_WORD, OP_SWAP, OP_NONE} acc_op_e;
  typedef enum logic [1:0] {SK_WHOLE, SK_ONE, SK_ALL, SK_NONE} sel_kind_e;

  typedef struct packed {
    logic [BANK_W-1:0] main_bank;
    logic [BANK_W-1:0] ix_bank;
    logic [BANK_W-1:0] iy_bank;
    logic              ix_alt;
    logic              iy_alt;
    logic              set_alt;
    logic              af_alt;
    logic              long_mode;
  } steer_t;
endpackage

// File: rtl/steer_reg.sv
module steer_reg
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        kind,
  input  logic [1:0]        byte_sel,
  input  logic [LONG_W-1:0] wdata,
  output logic [LONG_W-1:0] q,
  output steer_t            st
);
  sel_kind_e k;
  assign k = sel_kind_e'(kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr) begin
      if (k == SK_WHOLE) q <= wdata & STEER_MASK;
      for (int b = 1; b < LONG_W / BYTE_W; b++) begin
        if (k == SK_ALL || (k == SK_ONE && byte_sel == 2'(b)))
          q[b*BYTE_W +: BYTE_W] <= wdata[BYTE_W-1:0] & STEER_MASK[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign st.main_bank = q[POS_MAIN_BK +: BANK_W];
  assign st.ix_bank   = q[POS_IX_BK +: BANK_W];
  assign st.iy_bank   = q[POS_IY_BK +: BANK_W];
  assign st.ix_alt    = q[POS_IX_ALT];
  assign st.iy_alt    = q[POS_IY_ALT];
  assign st.set_alt   = q[POS_SET_ALT];
  assign st.af_alt    = q[POS_AF_ALT];
  assign st.long_mode = q[POS_LONG];
endmodule

// File: rtl/bank_store.sv
module bank_store
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  steer_t            st,
  input  logic              acc,
  input  logic [1:0]        op,
  input  logic              wr,
  input  logic [ID_W-1:0]   id,
  input  logic [LONG_W-1:0] wdata,
  output logic [LONG_W-1:0] rd_val
);
  logic [BYTE_W-1:0] byt  [NUM_BANKS][2][NUM_BYTES];
  logic [WORD_W-1:0] ixr  [NUM_BANKS][2];
  logic [WORD_W-1:0] iyr  [NUM_BANKS][2];
  logic [WORD_W-1:0] ext  [NUM_BANKS][2][NUM_PAIRS];

  acc_op_e           o;
  logic [BANK_W-1:0] mb;
  logic              byte_alt, is_pair;
  logic [1:0]        pi;
  logic [ID_W-1:0]   hb, lb;
  logic [WORD_W-1:0] pair_lo, pair_hi, af_word;

  assign o        = acc_op_e'(op);
  assign mb       = st.main_bank;
  assign byte_alt = (id < ID_W'(2)) ? st.af_alt : st.set_alt;
  assign is_pair  = (id >= ID_W'(1)) && (id <= ID_W'(NUM_PAIRS));
  assign pi       = is_pair ? 2'(id - ID_W'(1)) : 2'd0;
  assign hb       = ID_W'({pi, 1'b0}) + ID_W'(2);
  assign lb       = hb + ID_W'(1);
  assign pair_lo  = {byt[mb][st.set_alt][hb], byt[mb][st.set_alt][lb]};
  assign pair_hi  = ext[mb][st.set_alt][pi];
  assign af_word  = {byt[mb][st.af_alt][0], byt[mb][st.af_alt][1]};

  always_comb begin
    rd_val = '0;
    unique case (o)
      OP_BYTE: rd_val = LONG_W'(byt[mb][byte_alt][id]);
      OP_WORD: begin
        if (id == ID_W'(0))      rd_val = LONG_W'(af_word);
        else if (is_pair)        rd_val = {st.long_mode ? pair_hi : '0, pair_lo};
        else if (id == ID_W'(4)) rd_val = LONG_W'(ixr[st.ix_bank][st.ix_alt]);
        else if (id == ID_W'(5)) rd_val = LONG_W'(iyr[st.iy_bank][st.iy_alt]);
      end
      OP_SWAP: if (is_pair) rd_val = {pair_hi, pair_lo};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int a = 0; a < 2; a++) begin
          ixr[b][a] <= '0;
          iyr[b][a] <= '0;
          for (int r = 0; r < NUM_BYTES; r++) byt[b][a][r] <= '0;
          for (int p = 0; p < NUM_PAIRS; p++) ext[b][a][p] <= '0;
        end
      end
    end else if (acc) begin
      unique case (o)
        OP_BYTE: if (wr) byt[mb][byte_alt][id] <= wdata[BYTE_W-1:0];
        OP_WORD: if (wr) begin
          if (id == ID_W'(0)) begin
            byt[mb][st.af_alt][0] <= wdata[WORD_W-1:BYTE_W];
            byt[mb][st.af_alt][1] <= wdata[BYTE_W-1:0];
          end else if (is_pair) begin
            byt[mb][st.set_alt][hb] <= wdata[WORD_W-1:BYTE_W];
            byt[mb][st.set_alt][lb] <= wdata[BYTE_W-1:0];
            if (st.long_mode) ext[mb][st.set_alt][pi] <= wdata[LONG_W-1:WORD_W];
          end else if (id == ID_W'(4)) begin
            ixr[st.ix_bank][st.ix_alt] <= wdata[WORD_W-1:0];
          end else if (id == ID_W'(5)) begin
            iyr[st.iy_bank][st.iy_alt] <= wdata[WORD_W-1:0];
          end
        end
        OP_SWAP: if (is_pair) begin
          ext[mb][st.set_alt][pi]  <= pair_lo;
          byt[mb][st.set_alt][hb]  <= pair_hi[WORD_W-1:BYTE_W];
          byt[mb][st.set_alt][lb]  <= pair_hi[BYTE_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rsp_slot.sv
module rsp_slot
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LONG_W-1:0] in_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LONG_W-1:0] rsp_data,
  output logic              acc
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= in_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bankreg_core.sv
module bankreg_core
  import bankreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic        req_wr,
  input  logic [2:0]  req_id,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  input  logic        sel_wr,
  input  logic [1:0]  sel_kind,
  input  logic [1:0]  sel_byte,
  input  logic [31:0] sel_wdata,
  output logic [31:0] sel_rdata
);
  steer_t            st;
  logic              acc;
  logic [LONG_W-1:0] rd_val;

  steer_reg u_steer (
    .clk(clk), .rst_n(rst_n), .wr(sel_wr), .kind(sel_kind),
    .byte_sel(sel_byte), .wdata(sel_wdata), .q(sel_rdata), .st(st)
  );

  bank_store u_store (
    .clk(clk), .rst_n(rst_n), .st(st), .acc(acc), .op(req_op),
    .wr(req_wr), .id(req_id), .wdata(req_wdata), .rd_val(rd_val)
  );

  rsp_slot u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .in_data(rd_val), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .acc(acc)
  );
endmodule

// File: rtl/bankreg_core_chk.sv
module bankreg_core_chk
  import bankreg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_op,
  input logic        req_wr,
  input logic [2:0]  req_id,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        sel_wr,
  input logic [1:0]  sel_kind,
  input logic [1:0]  sel_byte,
  input logic [31:0] sel_wdata,
  input logic [31:0] sel_rdata
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rdata & ~STEER_MASK) == 32'h0);

  p_whole_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && sel_kind == 2'd0 |=> sel_rdata == ($past(sel_wdata) & STEER_MASK));

  p_low_byte_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && sel_kind == 2'd1 |=> sel_rdata[7:0] == $past(sel_rdata[7:0]));

  p_broadcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && sel_kind == 2'd2 |=>
      sel_rdata[31:8] == ({3{$past(sel_wdata[7:0])}} & STEER_MASK[31:8]));

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

bind bankreg_core bankreg_core_chk u_chk (.*);

// File: tb/bankreg_core_bench.sv
module bankreg_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic        req_wr = 1'b0;
  logic [2:0]  req_id = 3'd0;
  logic [31:0] req_wdata = 32'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        sel_wr = 1'b0;
  logic [1:0]  sel_kind = 2'd0;
  logic [1:0]  sel_byte = 2'd0;
  logic [31:0] sel_wdata = 32'h0;
  logic [31:0] sel_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  bankreg_core u_bankreg_core (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // response readiness pattern, changed at the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    rsp_ready <= !bp_on || (cyc % 3 == 0);
  end

  // monitor: pops the scoreboard and checks the hold rule (R12)
  initial begin
    bit          held = 1'b0;
    logic [31:0] held_data = 32'h0;
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (held) begin
          check("R12 hold valid", {31'b0, rsp_valid}, 32'd1);
          check("R12 hold data", rsp_data, held_data);
        end
        if (rsp_valid && rsp_ready) begin
          if (exp_q.size() == 0) begin
            check("R12 unexpected response", rsp_data, 32'hxxxx_xxxx);
          end else begin
            check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
          end
        end
        held = rsp_valid && !rsp_ready;
        if (held) begin
          check("R12 stall ready", {31'b0, req_ready}, 32'd0);
          held_data = rsp_data;
        end
      end
    end
  end

  task automatic access(input logic [1:0] op, input logic wr, input logic [2:0] id,
                        input logic [31:0] wd, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_wr = wr; req_id = id; req_wdata = wd;
    exp_q.push_back(exp); tag_q.push_back(tag);
    forever begin
      #5;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0; req_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic sel_write(input logic [1:0] kind, input logic [1:0] bsel,
                           input logic [31:0] wd, input logic [31:0] exp, input string tag);
    wait_idle();
    @(negedge clk);
    sel_wr = 1'b1; sel_kind = kind; sel_byte = bsel; sel_wdata = wd;
    @(negedge clk);
    sel_wr = 1'b0;
    #5;
    check(tag, sel_rdata, exp);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R1 steer reset", sel_rdata, 32'h0);
    check("R1 no response", {31'b0, rsp_valid}, 32'd0);

    // byte/word ids: byte A0 F1 B2 C3 D4 E5 H6 L7; word AF0 BC1 DE2 HL3 IX4 IY5
    access(2'd1, 0, 3'd1, 0, 32'h0, "R1 BC reset");
    access(2'd1, 0, 3'd4, 0, 32'h0, "R1 IX reset");
    access(2'd0, 1, 3'd0, 32'h11, 32'h0, "R13 write A returns old");
    access(2'd0, 1, 3'd1, 32'h22, 32'h0, "R13 write F returns old");
    access(2'd1, 0, 3'd0, 0, 32'h1122, "R6 AF word");
    access(2'd0, 1, 3'd0, 32'h99, 32'h11, "R13 old A");
    access(2'd0, 1, 3'd0, 32'h11, 32'h99, "R13 old A again");

    sel_write(2'd0, 2'd0, 32'h0000_0100, 32'h0000_0100, "R2 main bank 1");
    access(2'd0, 0, 3'd0, 0, 32'h0, "R6 bank1 A empty");
    access(2'd0, 1, 3'd0, 32'h33, 32'h0, "R6 bank1 A write");
    sel_write(2'd0, 2'd0, 32'h0, 32'h0, "R2 clear");
    access(2'd0, 0, 3'd0, 0, 32'h11, "R6 bank0 A kept");

    // same-cycle steering write and access (R5)
    wait_idle();
    @(negedge clk);
    sel_wr = 1'b1; sel_kind = 2'd0; sel_wdata = 32'h0000_0100;
    req_valid = 1'b1; req_op = 2'd0; req_wr = 1'b0; req_id = 3'd0;
    exp_q.push_back(32'h11); tag_q.push_back("R5 old steering used");
    #5;
    check("R5 accepted", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    sel_wr = 1'b0; req_valid = 1'b0;
    access(2'd0, 0, 3'd0, 0, 32'h33, "R5 new steering next");
    sel_write(2'd0, 2'd0, 32'h0, 32'h0, "R2 clear");

    // IX / IY groups (R7)
    access(2'd1, 1, 3'd4, 32'h0000_BEEF, 32'h0, "R7 IX write");
    sel_write(2'd0, 2'd0, 32'h0001_0000, 32'h0001_0000, "R2 IX alt");
    access(2'd1, 0, 3'd4, 0, 32'h0, "R7 IX alternate empty");
    access(2'd0, 0, 3'd0, 0, 32'h11, "R7 main unaffected by IX alt");
    sel_write(2'd0, 2'd0, 32'h0004_0000, 32'h0004_0000, "R2 IX bank 2");
    access(2'd1, 0, 3'd4, 0, 32'h0, "R7 IX bank2 empty");
    sel_write(2'd0, 2'd0, 32'h0, 32'h0, "R2 clear");
    access(2'd1, 0, 3'd4, 0, 32'hBEEF, "R7 IX back");
    access(2'd1, 1, 3'd5, 32'h0000_1234, 32'h0, "R7 IY write");
    sel_write(2'd0, 2'd0, 32'h0100_0000, 32'h0100_0000, "R2 IY alt");
    access(2'd1, 0, 3'd5, 0, 32'h0, "R7 IY alternate empty");
    access(2'd1, 0, 3'd4, 0, 32'hBEEF, "R7 IX unaffected by IY alt");
    sel_write(2'd0, 2'd0, 32'h0400_0000, 32'h0400_0000, "R2 IY bank 2");
    access(2'd1, 0, 3'd5, 0, 32'h0, "R7 IY bank2 empty");
    sel_write(2'd0, 2'd0, 32'h0000_0300, 32'h0000_0300, "R2 main bank 3");
    access(2'd1, 0, 3'd5, 0, 32'h1234, "R7 IY ignores main bank");
    sel_write(2'd0, 2'd0, 32'h0, 32'h0, "R2 clear");

    // alternates (R8)
    access(2'd0, 1, 3'd2, 32'h55, 32'h0, "R8 B write");
    sel_write(2'd0, 2'd0, 32'h0000_0002, 32'h0000_0002, "R2 set alt");
    access(2'd0, 0, 3'd2, 0, 32'h0, "R8 B alternate empty");
    access(2'd0, 0, 3'd0, 0, 32'h11, "R8 A not switched by set alt");
    sel_write(2'd0, 2'd0, 32'h0000_0001, 32'h0000_0001, "R2 AF alt");
    access(2'd0, 0, 3'd0, 0, 32'h0, "R8 A alternate empty");
    access(2'd0, 0, 3'd2, 0, 32'h55, "R8 B not switched by AF alt");
    sel_write(2'd0, 2'd0, 32'h0, 32'h0, "R2 clear");

    // word and long-word (R9, R10)
    access(2'd1, 1, 3'd1, 32'hAAAA_C0DE, 32'h0000_5500, "R13 BC old");
    access(2'd1, 0, 3'd1, 0, 32'h0000_C0DE, "R9 word read upper zero");
    sel_write(2'd0, 2'd0, 32'h0000_4000, 32'h0000_4000, "R2 long mode");
    access(2'd1, 0, 3'd1, 0, 32'h0000_C0DE, "R9 extension untouched");
    access(2'd1, 1, 3'd1, 32'h1357_2468, 32'h0000_C0DE, "R10 long write");
    access(2'd1, 0, 3'd1, 0, 32'h1357_2468, "R10 long read");
    sel_write(2'd0, 2'd0, 32'h0, 32'h0, "R2 word mode");
    access(2'd1, 1, 3'd1, 32'h9999_ABCD, 32'h0000_2468, "R9 word write old");
    sel_write(2'd0, 2'd0, 32'h0000_4000, 32'h0000_4000, "R2 long mode");
    access(2'd1, 0, 3'd1, 0, 32'h1357_ABCD, "R9 extension kept");
    access(2'd1, 0, 3'd0, 0, 32'h0000_1122, "R10 AF upper zero");
    access(2'd1, 0, 3'd4, 0, 32'h0000_BEEF, "R10 IX upper zero");
    access(2'd1, 0, 3'd2, 0, 32'h0, "R10 DE empty");
    access(2'd1, 0, 3'd6, 0, 32'h0, "R9 id 6 reads zero");
    access(2'd0, 0, 3'd2, 0, 32'hAB, "R6 B byte");

    // swap (R11)
    access(2'd2, 0, 3'd1, 0, 32'h1357_ABCD, "R11 swap returns old");
    access(2'd1, 0, 3'd1, 0, 32'hABCD_1357, "R11 halves swapped");
    access(2'd2, 1, 3'd0, 0, 32'h0, "R11 swap AF returns zero");
    access(2'd1, 0, 3'd0, 0, 32'h0000_1122, "R11 AF unchanged");
    sel_write(2'd0, 2'd0, 32'h0, 32'h0, "R2 word mode");
    access(2'd1, 0, 3'd1, 0, 32'h0000_1357, "R11 low half after swap");

    // steering port forms (R2, R3, R4)
    sel_write(2'd0, 2'd0, 32'hFFFF_FFFF, 32'h0707_4303, "R2 reserved bits zero");
    sel_write(2'd1, 2'd3, 32'h0000_00AA, 32'h0207_4303, "R3 byte 3 alone");
    sel_write(2'd1, 2'd0, 32'h0000_0000, 32'h0207_4303, "R3 byte 0 ignored");
    sel_write(2'd1, 2'd2, 32'h0000_0000, 32'h0200_4303, "R3 byte 2 alone");
    sel_write(2'd2, 2'd0, 32'h0000_0005, 32'h0505_0103, "R4 broadcast");
    sel_write(2'd0, 2'd0, 32'h0, 32'h0, "R2 clear");

    // back-pressure (R12)
    wait_idle();
    bp_on = 1'b1;
    access(2'd1, 0, 3'd0, 0, 32'h1122, "R12 AF under stall");
    access(2'd0, 0, 3'd0, 0, 32'h11, "R12 A under stall");
    access(2'd1, 0, 3'd1, 0, 32'h1357, "R12 BC under stall");
    access(2'd1, 0, 3'd4, 0, 32'hBEEF, "R12 IX under stall");
    access(2'd0, 1, 3'd4, 32'h77, 32'h0, "R12 D write under stall");
    access(2'd0, 0, 3'd4, 0, 32'h77, "R12 D read under stall");
    wait_idle();
    bp_on = 1'b0;
    wait_idle();
    check("R12 queue drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule